// File: doc/BRIEF.md
# Serial Two-State Trellis Check-Node Processor

This block is the message kernel of a layered soft-decision decoder for sparse parity-check codes. It handles one parity-check row at a time. Prior messages for the row arrive serially, one per edge, and the last edge is flagged. The block treats the row as a two-state trellis of a single parity check. It runs a forward recursion as the messages arrive and a backward recursion once the row is complete. A combining pass then emits one extrinsic message per edge. Each extrinsic message is built from every input of the row except the input of its own edge.

All merging goes through one pairwise operator. The operator is a piecewise-linear correction of the max function, with a correction constant and a slope of one quarter. Messages are signed 6-bit values with 2 fraction bits. The correction constant defaults to 2 (0.5). Intermediate arithmetic runs on wider values, and only each operator result is clipped back to 6 bits.

The controller has three states:
- LOAD accepts edges.
- BACK walks the stored row from its last edge down to its first.
- EMIT streams the results in edge order.

It has four transitions:
- LOAD→BACK happens on the delimiter, or when the row buffer is full.
- BACK→BACK repeats until edge 0 is processed.
- BACK→EMIT follows the backward step for edge 0.
- EMIT→LOAD follows the last output.

Top module: `spc_trellis_siso`

## Requirements
- R1: While reset is held, and in the first cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R2: While `in_ready` is 1, every cycle with `in_valid` high stores one message as the next edge. A cycle that also has `in_last` high closes the row, and `in_ready` is 0 in the following cycle.
- R3: If `DEG_MAX` (default 32) edges are accepted without `in_last`, the row closes after the edge numbered `DEG_MAX`-1 (counting from 0). The next offered message then starts a new row.
- R4: The pairwise operator is defined as follows, with values in units of 1/4:
  - Q(x,y) = max(x,y) + max(K−⌊|x−y|/4⌋,0) − max(K−⌊|x+y|/4⌋,0) − max(x+y,0), where K = `CONST_Q` = 2.
  - The result is clipped to [−32, 31].
  - `in_msg` and `out_msg` are two's-complement values.
- R5: Let the row's inputs be ρ0..ρc−1. The forward values are f0=ρ0 and fk=Q(fk−1,ρk). The backward values are bc−1=ρc−1 and bk=Q(ρk,bk+1). For an inner edge j, the output is Q(fj−1,bj+1).
- R6: Edge 0 outputs b1, and the last edge outputs fc−2. A row of a single edge outputs 0.
- R7: After the cycle that closes a row of c edges, `out_valid` stays 0 for exactly c cycles. It is then 1 for c consecutive cycles carrying edges 0..c−1 in order, and `out_last` is high only with edge c−1.
- R8: While `in_ready` is 0, `in_valid`, `in_msg` and `in_last` have no effect on the outputs of the current row or of any later row.
- R9: In the cycle after the output carrying `out_last`, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A prior message is offered |
| in_msg | input | MSG_W | Prior message, signed, 2 fraction bits |
| in_last | input | 1 | Offered message is the last edge of its row |
| in_ready | output | 1 | Block is collecting a row |
| out_valid | output | 1 | An extrinsic message is on `out_msg` |
| out_msg | output | MSG_W | Extrinsic message, signed |
| out_last | output | 1 | Output belongs to the last edge of the row |

## Verification
The operator is swept over every pair of 6-bit values, using three-edge rows of the form (x, y, x). The outer outputs expose Q(y,x) and Q(x,y), so a mistake in one argument order or in symmetry shows up, and the middle output exposes Q(x,x). Rows of lengths 1, 2, 5, 17 and 32 separate the endpoint rules from the inner combining rule, and check that long folds keep their ordering. A 32-edge row sent without a delimiter, followed by a one-edge row, distinguishes a forced close from a missed close. Junk offered with `in_valid` high throughout every busy period would corrupt later rows if it were taken.

// File: rtl/spc_trellis_pkg.sv
package spc_trellis_pkg;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_BACK = 2'd1,
        ST_EMIT = 2'd2
    } trellis_state_t;

endpackage

// File: rtl/msg_sat.sv
module msg_sat #(
    parameter int IN_W  = 9,
    parameter int OUT_W = 6
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam int HI_I = (1 << (OUT_W - 1)) - 1;
    localparam int LO_I = -HI_I - 1;
    localparam logic signed [IN_W-1:0] HI = IN_W'(HI_I);
    localparam logic signed [IN_W-1:0] LO = IN_W'(LO_I);

    always_comb begin
        if (din > HI) begin
            dout = HI[OUT_W-1:0];
        end else if (din < LO) begin
            dout = LO[OUT_W-1:0];
        end else begin
            dout = din[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/qop_unit.sv
module qop_unit #(
    parameter int MSG_W   = 6,
    parameter int CONST_Q = 2
) (
    input  logic signed [MSG_W-1:0] a,
    input  logic signed [MSG_W-1:0] b,
    output logic signed [MSG_W-1:0] r
);
    localparam int EW    = MSG_W + 3;
    localparam int SLOPE = 2;
    localparam logic signed [EW-1:0] KC = EW'(CONST_Q);

    logic signed [EW-1:0] xa, yb, mx, dif, adif, sm, asm;
    logic signed [EW-1:0] c1, c2, t1, t2, t3, acc;

    always_comb begin
        xa   = EW'(a);
        yb   = EW'(b);
        mx   = (xa > yb) ? xa : yb;
        dif  = xa - yb;
        adif = (dif < 0) ? -dif : dif;
        sm   = xa + yb;
        asm  = (sm < 0) ? -sm : sm;
        c1   = KC - (adif >>> SLOPE);
        c2   = KC - (asm >>> SLOPE);
        t1   = (c1 < 0) ? '0 : c1;
        t2   = (c2 < 0) ? '0 : c2;
        t3   = (sm < 0) ? '0 : sm;
        acc  = mx + t1 - t2 - t3;
    end

    msg_sat #(.IN_W(EW), .OUT_W(MSG_W)) u_sat (
        .din  (acc),
        .dout (r)
    );
endmodule

// File: rtl/spc_trellis_siso.sv
module spc_trellis_siso
    import spc_trellis_pkg::*;
#(
    parameter int MSG_W   = 6,
    parameter int CONST_Q = 2,
    parameter int DEG_MAX = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [MSG_W-1:0] in_msg,
    input  logic             in_last,
    output logic             in_ready,
    output logic             out_valid,
    output logic [MSG_W-1:0] out_msg,
    output logic             out_last
);
    localparam int IDX_W = (DEG_MAX > 1) ? $clog2(DEG_MAX) : 1;
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DEG_MAX - 1);

    trellis_state_t state_q, state_d;
    logic [IDX_W-1:0] idx_q, lst_q, idx_m1, idx_p1;

    logic signed [MSG_W-1:0] rho_q [DEG_MAX];
    logic signed [MSG_W-1:0] fwd_q [DEG_MAX];
    logic signed [MSG_W-1:0] bwd_q [DEG_MAX];
    logic signed [MSG_W-1:0] fwd_new, bwd_new, cmb_val;

    logic take, row_close;

    assign idx_m1    = idx_q - 1'b1;
    assign idx_p1    = idx_q + 1'b1;
    assign take      = (state_q == ST_LOAD) && in_valid;
    assign row_close = in_last || (idx_q == IDX_TOP);

    qop_unit #(.MSG_W(MSG_W), .CONST_Q(CONST_Q)) u_fwd (
        .a (fwd_q[idx_m1]),
        .b ($signed(in_msg)),
        .r (fwd_new)
    );

    qop_unit #(.MSG_W(MSG_W), .CONST_Q(CONST_Q)) u_bwd (
        .a (rho_q[idx_q]),
        .b (bwd_q[idx_p1]),
        .r (bwd_new)
    );

    qop_unit #(.MSG_W(MSG_W), .CONST_Q(CONST_Q)) u_cmb (
        .a (fwd_q[idx_m1]),
        .b (bwd_q[idx_p1]),
        .r (cmb_val)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: if (in_valid && row_close) state_d = ST_BACK;
            ST_BACK: if (idx_q == '0)           state_d = ST_EMIT;
            ST_EMIT: if (idx_q == lst_q)        state_d = ST_LOAD;
            default:                            state_d = ST_LOAD;
        endcase
    end

    // edge pointer and row length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            lst_q <= '0;
        end else begin
            unique case (state_q)
                ST_LOAD: begin
                    if (in_valid) begin
                        if (row_close) begin
                            lst_q <= idx_q;
                        end else begin
                            idx_q <= idx_p1;
                        end
                    end
                end
                ST_BACK: begin
                    if (idx_q != '0) idx_q <= idx_m1;
                end
                ST_EMIT: begin
                    idx_q <= (idx_q == lst_q) ? '0 : idx_p1;
                end
                default: idx_q <= '0;
            endcase
        end
    end

    // row buffers
    always_ff @(posedge clk) begin
        if (take) begin
            rho_q[idx_q] <= $signed(in_msg);
            fwd_q[idx_q] <= (idx_q == '0) ? $signed(in_msg) : fwd_new;
        end
        if (state_q == ST_BACK) begin
            bwd_q[idx_q] <= (idx_q == lst_q) ? rho_q[idx_q] : bwd_new;
        end
    end

    // outputs
    always_comb begin
        in_ready  = (state_q == ST_LOAD);
        out_valid = (state_q == ST_EMIT);
        out_last  = out_valid && (idx_q == lst_q);
        out_msg   = '0;
        if (out_valid && (lst_q != '0)) begin
            if (idx_q == '0) begin
                out_msg = bwd_q[1];
            end else if (idx_q == lst_q) begin
                out_msg = fwd_q[idx_m1];
            end else begin
                out_msg = cmb_val;
            end
        end
    end

    AST_CLOSE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready); // R2

    AST_BURST_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid); // R7

    AST_BURST_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |=> (!out_valid && in_ready)); // R9

    AST_EMIT_AFTER_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(!in_ready)); // R7

endmodule

// File: tb/spc_trellis_siso_test.sv
module spc_trellis_siso_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [5:0] in_msg = '0;
    logic       in_last = 1'b0;
    logic       in_ready, out_valid, out_last;
    logic [5:0] out_msg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int row [64];
    int expv[64];

    always #5 clk = ~clk;

    spc_trellis_siso uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msg(in_msg),
        .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
        .out_msg(out_msg), .out_last(out_last)
    );

    function automatic int sat6(int v);
        if (v > 31)  return 31;
        if (v < -32) return -32;
        return v;
    endfunction

    function automatic int qm(int x, int y);
        int mx, d, s, as, t1, t2, t3;
        mx = (x > y) ? x : y;
        d  = (x > y) ? x - y : y - x;
        s  = x + y;
        as = (s < 0) ? -s : s;
        t1 = 2 - d / 4;  if (t1 < 0) t1 = 0;
        t2 = 2 - as / 4; if (t2 < 0) t2 = 0;
        t3 = (s > 0) ? s : 0;
        return sat6(mx + t1 - t2 - t3);
    endfunction

    task automatic expect_row(int n);
        int f[64];
        int b[64];
        f[0] = row[0];
        for (int k = 1; k < n; k++) f[k] = qm(f[k-1], row[k]);
        b[n-1] = row[n-1];
        for (int k = n - 2; k >= 0; k--) b[k] = qm(row[k], b[k+1]);
        for (int j = 0; j < n; j++) begin
            if (n == 1)          expv[j] = 0;
            else if (j == 0)     expv[j] = b[1];
            else if (j == n - 1) expv[j] = f[n-2];
            else                 expv[j] = qm(f[j-1], b[j+1]);
        end
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // send row[0..n-1]; close selects whether in_last marks the final edge
    task automatic run_row(int n, bit close, string vtag);
        int gap;
        expect_row(n);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            in_valid = 1'b1;
            in_msg   = row[k][5:0];
            in_last  = close && (k == n - 1);
            @(negedge clk);
        end
        // R8: junk offered for the whole busy period
        in_valid = 1'b1;
        in_msg   = 6'h15;
        in_last  = 1'b1;
        gap = 0;
        while (!out_valid && gap < 100) begin
            gap++;
            @(negedge clk);
        end
        chk("R7 gap", gap, n);
        for (int j = 0; j < n; j++) begin
            chk("R7 valid", int'(out_valid), 1);
            chk((j == 0 || j == n - 1) ? "R6 endpoint" : vtag,
                int'($signed(out_msg)), expv[j]);
            chk("R7 last", int'(out_last), (j == n - 1) ? 1 : 0);
            if (j == n - 1) in_valid = 1'b0;
            @(negedge clk);
        end
        chk("R9 ready", int'(in_ready), 1);
        chk("R9 idle", int'(out_valid), 0);
    endtask

    initial begin
        for (int c = 0; c < 190000; c++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", int'(in_ready), 1);
        chk("R1 valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", int'(in_ready), 1);
        chk("R1 valid", int'(out_valid), 0);

        // R4: every operand pair through a three-edge row (x, y, x)
        for (int x = -32; x < 32; x++) begin
            for (int y = -32; y < 32; y++) begin
                row[0] = x; row[1] = y; row[2] = x;
                run_row(3, 1'b1, "R4 pair");
            end
        end

        // R6: single edge yields zero
        row[0] = 17;
        run_row(1, 1'b1, "R6 single");
        row[0] = -9; row[1] = 22;
        run_row(2, 1'b1, "R6 pair");

        // R5: longer rows, inner combining
        for (int k = 0; k < 5; k++)  row[k] = ((k * 37 + 11) % 64) - 32;
        run_row(5, 1'b1, "R5 len5");
        for (int k = 0; k < 17; k++) row[k] = ((k * 23 + 5) % 64) - 32;
        run_row(17, 1'b1, "R5 len17");
        for (int k = 0; k < 32; k++) row[k] = ((k * 45 + 30) % 64) - 32;
        run_row(32, 1'b1, "R5 len32");

        // R3: full buffer closes the row without a delimiter
        for (int k = 0; k < 32; k++) row[k] = ((k * 13 + 7) % 64) - 32;
        run_row(32, 1'b0, "R3 forced");
        row[0] = -20;
        run_row(1, 1'b1, "R3 next row");

        // R2: a row following the forced close is handled normally
        row[0] = 12; row[1] = -3; row[2] = 30; row[3] = -31;
        run_row(4, 1'b1, "R2 row");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule